// File: doc/BRIEF.md
# NAND Flash Bus Operation Sequencer

This block turns one control-word write from a host into one complete operation on an 8-bit NAND flash bus. The host first loads a column address, a row address, an address-size word, a packed wait-count word and, for programming, a data word. It then writes a control word with the launch bit set. The engine steps through the phases that the control word enables, in a fixed order: first command byte, column address bytes, row address bytes, a lone special address byte, second command byte, then one or four data bytes. After that it waits on the ready/busy line of the flash.

A chip-enable hold bit in the control word keeps the chip enable low once the operation finishes. This lets a sequence of control words form one transaction: for example, a page-read set-up followed by a chain of data reads. Read data lands in the data register. The host polls the control register to see the launch bit drop and the ready or error flag rise.

Top module: `nand_seq`

## Requirements
- R1: Writing register 0 (control) with bit 31 set while idle starts an operation. Bit 31 reads as 1 from the next cycle until the operation finishes, then reads as 0.
- R2: Control bit 16 sends one command byte, control[7:0], with CLE high. Control bit 19 sends control[15:8] with CLE high after all address bytes. Each byte is latched on the rising edge of the write strobe.
- R3: Control bit 17 sends the column register (register 1) and bit 18 the row register (register 2) as ALE bytes, least-significant byte first. The byte counts are cfg[5:4]+1 and cfg[7:6]+1, where cfg is register 3. Column bytes precede row bytes.
- R4: Control bit 24 sends one ALE byte equal to column[7:0], after row bytes and before the second command.
- R5: Control bit 20 reads data with the read strobe, placing the byte of the k-th strobe in data register (register 5) bits [8k+7:8k]. Control[29:28]=3 reads four bytes; any other value reads one byte and leaves data bits 31:8 unchanged.
- R6: Control bit 21 (with bit 20 clear) writes the data register on the bus, least-significant byte first, four bytes when control[29:28]=3, else one byte, with CLE and ALE low.
- R7: With control bit 30 set, chip enable stays low after the operation. The next operation with bit 30 clear releases it (chip enable high) at its end.
- R8: After the strobes, the engine waits w4 cycles, then sets control bit 26 (ready) once the ready/busy input reads 1. If the input stays 0 for WDOG_CYCLES cycles, it sets control bit 27 (error) instead. Both flags clear at the next launch.
- R9: Register 4 packs five 6-bit wait counts w0..w4 at bits 0, 6, 12, 18, 24. A strobe stays low for w0 cycles and high for w1 cycles, and a count of 0 acts as 1.
- R10: Host writes to any register while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register select: 0 control, 1 column, 2 row, 3 cfg, 4 waits, 5 data |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read data of the selected register |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven by the engine |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus byte from the flash |
| nand_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
The bound checker watches pin-level rules on every cycle:
- CLE and ALE never high together.
- Only one strobe active at a time.
- A strobe only while chip enable is low and an operation is running.
- No bus drive during a read strobe.
- Ready and error never both set, and one of them set whenever an operation ends.

Only the bench scenarios show the order and values of command, address and data bytes, the little-endian packing of read data, strobe widths, hold-chained transactions, the watchdog error and that writes during an operation are ignored.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int WORD_W = 32;
    localparam int WAIT_W = 6;
    localparam int N_WAIT = 5;
    localparam int CNT_W  = 16;

    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_CMD1, S_COL, S_ROW, S_SPEC, S_CMD2, S_DATA,
        S_HOLD, S_BUSY, S_RB
    } step_e;

    typedef struct packed {
        step_e                step;
        logic                 low;
        logic [1:0]           bidx;
        logic [CNT_W-1:0]     cnt;
        logic                 ce_n;
        logic                 busy;
        logic                 ready;
        logic                 err;
        logic [WORD_W-1:0]    ctrl;
        logic [WORD_W-1:0]    col;
        logic [WORD_W-1:0]    row;
        logic [WORD_W-1:0]    data;
        logic [7:0]           cfg;
        logic [N_WAIT*WAIT_W-1:0] waits;
    } seq_t;
endpackage

// File: rtl/nand_seq_waits.sv
module nand_seq_waits
    import nand_seq_pkg::*;
(
    input  logic [N_WAIT*WAIT_W-1:0] waits,
    output logic [CNT_W-1:0]         load [N_WAIT]
);
    for (genvar g = 0; g < N_WAIT; g++) begin : g_field
        logic [WAIT_W-1:0] f;
        assign f = waits[g*WAIT_W +: WAIT_W];
        assign load[g] = (f == '0) ? '0 : CNT_W'(f - 1'b1);
    end
endmodule

// File: rtl/nand_seq_rdmux.sv
module nand_seq_rdmux
    import nand_seq_pkg::*;
(
    input  logic [2:0]               addr,
    input  logic [WORD_W-1:0]        ctrl,
    input  logic                     busy,
    input  logic                     ready,
    input  logic                     err,
    input  logic [WORD_W-1:0]        col,
    input  logic [WORD_W-1:0]        row,
    input  logic [7:0]               cfg,
    input  logic [N_WAIT*WAIT_W-1:0] waits,
    input  logic [WORD_W-1:0]        data,
    output logic [WORD_W-1:0]        rdata
);
    always_comb begin
        case (addr)
            3'd0:    rdata = {busy, ctrl[30:28], err, ready, ctrl[25:0]};
            3'd1:    rdata = col;
            3'd2:    rdata = row;
            3'd3:    rdata = {24'd0, cfg};
            3'd4:    rdata = WORD_W'(waits);
            3'd5:    rdata = data;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int WDOG_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rb
);
    localparam logic [CNT_W-1:0] WDOG_LOAD = CNT_W'(WDOG_CYCLES - 1);

    seq_t             q, n;
    logic [CNT_W-1:0] wl [N_WAIT];
    logic             go;
    step_e            tgt;
    logic             byte_step, is_read;
    logic [1:0]       nb;
    logic             busy_w, ready_w, err_w;

    nand_seq_waits u_waits (.waits(q.waits), .load(wl));

    nand_seq_rdmux u_rd (
        .addr(host_addr), .ctrl(q.ctrl), .busy(q.busy), .ready(q.ready),
        .err(q.err), .col(q.col), .row(q.row), .cfg(q.cfg),
        .waits(q.waits), .data(q.data), .rdata(host_rdata)
    );

    // next enabled phase after s, in bus order
    function automatic step_e first_after(step_e s, logic [WORD_W-1:0] c);
        if (s < S_CMD1 && c[16]) return S_CMD1;
        if (s < S_COL  && c[17]) return S_COL;
        if (s < S_ROW  && c[18]) return S_ROW;
        if (s < S_SPEC && c[24]) return S_SPEC;
        if (s < S_CMD2 && c[19]) return S_CMD2;
        if (s < S_DATA && (c[20] || c[21])) return S_DATA;
        return c[30] ? S_BUSY : S_HOLD;
    endfunction

    assign byte_step = (q.step >= S_CMD1) && (q.step <= S_DATA);
    assign is_read   = (q.step == S_DATA) && q.ctrl[20];

    always_comb begin
        case (q.step)
            S_COL:   nb = q.cfg[5:4];
            S_ROW:   nb = q.cfg[7:6];
            S_DATA:  nb = (q.ctrl[29:28] == 2'b11) ? 2'd3 : 2'd0;
            default: nb = 2'd0;
        endcase
    end

    always_comb begin
        n   = q;
        go  = 1'b0;
        tgt = S_IDLE;
        case (q.step)
            S_IDLE: begin
                if (host_wr) begin
                    case (host_addr)
                        3'd0: begin
                            n.ctrl = host_wdata;
                            if (host_wdata[31]) begin
                                n.busy  = 1'b1;
                                n.ready = 1'b0;
                                n.err   = 1'b0;
                                n.ce_n  = 1'b0;
                                go      = 1'b1;
                                tgt     = q.ce_n ? S_SETUP
                                                 : first_after(S_SETUP, host_wdata);
                            end
                        end
                        3'd1:    n.col   = host_wdata;
                        3'd2:    n.row   = host_wdata;
                        3'd3:    n.cfg   = host_wdata[7:0];
                        3'd4:    n.waits = host_wdata[N_WAIT*WAIT_W-1:0];
                        3'd5:    n.data  = host_wdata;
                        default: ;
                    endcase
                end
            end
            S_SETUP, S_HOLD, S_BUSY: begin
                if (q.cnt == '0) begin
                    go = 1'b1;
                    if (q.step == S_SETUP) begin
                        tgt = first_after(S_SETUP, q.ctrl);
                    end else if (q.step == S_HOLD) begin
                        n.ce_n = 1'b1;
                        tgt    = S_BUSY;
                    end else begin
                        tgt = S_RB;
                    end
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            S_RB: begin
                if (nand_rb) begin
                    n.ready = 1'b1;
                    n.busy  = 1'b0;
                    n.step  = S_IDLE;
                end else if (q.cnt == '0) begin
                    n.err  = 1'b1;
                    n.busy = 1'b0;
                    n.step = S_IDLE;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                if (q.low) begin
                    if (q.cnt == '0) begin
                        if (is_read) n.data[8*q.bidx +: 8] = nand_io_in;
                        n.low = 1'b0;
                        n.cnt = wl[1];
                    end else begin
                        n.cnt = q.cnt - 1'b1;
                    end
                end else if (q.cnt != '0) begin
                    n.cnt = q.cnt - 1'b1;
                end else if (q.bidx == nb) begin
                    go  = 1'b1;
                    tgt = first_after(q.step, q.ctrl);
                end else begin
                    n.bidx = q.bidx + 1'b1;
                    n.low  = 1'b1;
                    n.cnt  = wl[0];
                end
            end
        endcase
        if (go) begin
            n.step = tgt;
            n.low  = 1'b1;
            n.bidx = '0;
            case (tgt)
                S_SETUP: n.cnt = wl[2];
                S_HOLD:  n.cnt = wl[3];
                S_BUSY:  n.cnt = wl[4];
                S_RB:    n.cnt = WDOG_LOAD;
                default: n.cnt = wl[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.step <= S_IDLE;
            q.ce_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        case (q.step)
            S_CMD1:        nand_io_out = q.ctrl[7:0];
            S_CMD2:        nand_io_out = q.ctrl[15:8];
            S_COL:         nand_io_out = q.col[8*q.bidx +: 8];
            S_ROW:         nand_io_out = q.row[8*q.bidx +: 8];
            S_SPEC:        nand_io_out = q.col[7:0];
            S_DATA:        nand_io_out = q.data[8*q.bidx +: 8];
            default:       nand_io_out = 8'h00;
        endcase
    end

    assign nand_ce_n  = q.ce_n;
    assign nand_cle   = (q.step == S_CMD1) || (q.step == S_CMD2);
    assign nand_ale   = (q.step == S_COL) || (q.step == S_ROW) || (q.step == S_SPEC);
    assign nand_we_n  = !(byte_step && q.low && !is_read);
    assign nand_re_n  = !(is_read && q.low);
    assign nand_io_oe = byte_step && !is_read;

    assign busy_w  = q.busy;
    assign ready_w = q.ready;
    assign err_w   = q.err;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic io_oe,
    input logic busy,
    input logic ready,
    input logic err
);
    a_r2_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    a_r7_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);
    a_r1_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> busy);
    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && err));
    a_r8_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ready || err));
endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(nand_ce_n), .cle(nand_cle),
    .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n), .io_oe(nand_io_oe),
    .busy(busy_w), .ready(ready_w), .err(err_w)
);

// File: tb/sim_nand_seq.sv
`timescale 1ns/1ps
module sim_nand_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb = 1'b1;

    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    nand_seq #(.WDOG_CYCLES(100)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    // flash model: log latched bytes, feed a counting read pattern
    logic [9:0] ev [256];
    int ev_n = 0, rd_n = 0, low_w = 0, last_low = 0;
    logic p_we = 1'b1, p_re = 1'b1, p_cle = 1'b0, p_ale = 1'b0;
    logic [7:0] p_io = '0;
    assign nand_io_in = 8'hA0 + rd_n[7:0];

    always @(posedge clk) begin
        if (p_we && !nand_we_n) low_w = 0;
        if (!nand_we_n) low_w = low_w + 1;
        if (!p_we && nand_we_n) begin
            ev[ev_n % 256] = {p_cle, p_ale, p_io};
            ev_n = ev_n + 1;
            last_low = low_w;
        end
        if (!p_re && nand_re_n) rd_n = rd_n + 1;
        p_we = nand_we_n; p_re = nand_re_n;
        p_cle = nand_cle; p_ale = nand_ale; p_io = nand_io_out;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(3'd0, v);
            if (!v[31]) break;
        end
    endtask

    typedef struct packed {
        logic [31:0] ctrl, col, row, cfg, dpre;
        logic [63:0] tag;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{32'h8001_00FF, 32'h0, 32'h0, 32'h00, 32'h0, "R2"},
        '{32'h800F_3000, 32'h0000_0123, 32'h0004_5678, 32'h90, 32'h0, "R3"},
        '{32'h8111_0090, 32'h0, 32'h0, 32'h00, 32'h1122_3344, "R4"},
        '{32'hB010_0000, 32'h0, 32'h0, 32'h00, 32'h0, "R5"},
        '{32'hB020_0000, 32'h0, 32'h0, 32'h00, 32'hDEAD_BEEF, "R6"},
        '{32'h800D_D060, 32'h0, 32'h0000_00AB, 32'h40, 32'h0, "R3"}
    };

    logic [9:0] xe [16];
    int xn;

    task automatic expect_events(input vec_t v);
        int nd;
        xn = 0;
        nd = (v.ctrl[29:28] == 2'b11) ? 4 : 1;
        if (v.ctrl[16]) begin xe[xn] = {2'b10, v.ctrl[7:0]}; xn++; end
        if (v.ctrl[17]) for (int i = 0; i <= int'(v.cfg[5:4]); i++) begin
            xe[xn] = {2'b01, v.col[8*i +: 8]}; xn++; end
        if (v.ctrl[18]) for (int i = 0; i <= int'(v.cfg[7:6]); i++) begin
            xe[xn] = {2'b01, v.row[8*i +: 8]}; xn++; end
        if (v.ctrl[24]) begin xe[xn] = {2'b01, v.col[7:0]}; xn++; end
        if (v.ctrl[19]) begin xe[xn] = {2'b10, v.ctrl[15:8]}; xn++; end
        if (!v.ctrl[20] && v.ctrl[21]) for (int i = 0; i < nd; i++) begin
            xe[xn] = {2'b00, v.dpre[8*i +: 8]}; xn++; end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v, dexp;
        int eb, rb, bad, nd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, v);
        check("reset R1 ctrl", v, 32'h0);
        check("reset R7 pins", {29'd0, nand_ce_n, nand_we_n, nand_re_n}, 32'h7);

        // vector table: R2 R3 R4 R5 R6
        foreach (VEC[k]) begin
            wr(3'd1, VEC[k].col); wr(3'd2, VEC[k].row);
            wr(3'd3, VEC[k].cfg); wr(3'd5, VEC[k].dpre);
            expect_events(VEC[k]);
            eb = ev_n; rb = rd_n;
            wr(3'd0, VEC[k].ctrl);
            rd(3'd0, v);
            check("R1 start reads busy", {31'd0, v[31]}, 32'd1);
            wait_done();
            bad = (ev_n - eb != xn) ? 1 : 0;
            for (int i = 0; i < xn; i++)
                if (ev[(eb + i) % 256] !== xe[i]) bad = 1;
            check($sformatf("%s bus bytes vec%0d", VEC[k].tag, k), 32'(bad), 32'd0);
            dexp = VEC[k].dpre;
            nd = (VEC[k].ctrl[29:28] == 2'b11) ? 4 : 1;
            if (VEC[k].ctrl[20])
                for (int i = 0; i < nd; i++) dexp[8*i +: 8] = 8'hA0 + 8'(rb + i);
            rd(3'd5, v);
            check($sformatf("R5 data reg vec%0d", k), v, dexp);
            rd(3'd0, v);
            check("R1 R8 done flags", {29'd0, v[31], v[27], v[26]}, 32'h1);
            check("R7 ce released", {31'd0, nand_ce_n}, 32'd1);
        end

        // R7: chained transaction under one chip enable
        eb = ev_n;
        wr(3'd0, 32'hC001_0070);
        wait_done();
        check("R7 ce held", {31'd0, nand_ce_n}, 32'd0);
        wr(3'd0, 32'h8010_0000);
        wait_done();
        check("R7 ce released at end", {31'd0, nand_ce_n}, 32'd1);
        check("R7 one cmd byte", 32'(ev_n - eb), 32'd1);

        // R9: strobe low width from w0, high width w1
        wr(3'd4, 32'h0000_0083);
        wr(3'd0, 32'h8001_0011);
        wait_done();
        check("R9 strobe low width", 32'(last_low), 32'd3);
        wr(3'd4, 32'h0);

        // R8: wait for ready/busy
        nand_rb = 1'b0;
        wr(3'd0, 32'h8001_0010);
        repeat (20) @(negedge clk);
        rd(3'd0, v);
        check("R8 busy while flash busy", {31'd0, v[31]}, 32'd1);
        // R10: writes during operation ignored
        wr(3'd1, 32'h0000_FFFF);
        wr(3'd0, 32'h8001_00AA);
        nand_rb = 1'b1;
        wait_done();
        rd(3'd0, v);
        check("R8 ready after flash ready", {30'd0, v[27], v[26]}, 32'd1);
        check("R10 ctrl unchanged", {24'd0, v[7:0]}, 32'h10);
        rd(3'd1, v);
        check("R10 col unchanged", v, 32'h0000_0000);

        // R8: watchdog error
        nand_rb = 1'b0;
        wr(3'd0, 32'h8001_0020);
        wait_done();
        rd(3'd0, v);
        check("R8 watchdog error", {29'd0, v[31], v[27], v[26]}, 32'h2);
        nand_rb = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule